// File: doc/BRIEF.md
# Radix-4 FFT Butterfly Stage

This block is one stage element of a streaming fast Fourier transform. On every clock it accepts four complex samples, each with its own twiddle index. Each sample is rotated by the twiddle factor for its index, taken from one shared quarter-wave sine table. The four rotated values are then combined by the radix-4 kernel into four complex results. The stage is fully pipelined. A new butterfly can enter on every cycle, and the results leave a fixed number of cycles later, marked by a delayed copy of the input strobe.

Stages are meant to be cascaded. Six of them, with reordering memory between them, make a 4096-point transform, because 4^6 = 4096. Samples are 16-bit signed I/Q. Twiddles are 16-bit signed fractions with 15 fraction bits. Each product is rounded to nearest, so that rounding error stays small across six stages. The outputs carry enough growth bits that full-scale inputs cannot wrap.

Lane l of every packed port occupies bits [l*W +: W], where W is that port's per-lane width. Lanes 0..3 of the input are the butterfly legs a, b, c, d. Lanes 0..3 of the output are X0..X3.

Top module: `r4_bfly_stage`

## Requirements
- R1: While rst_n is low, out_valid and every output lane are 0. After reset, out_valid stays 0 until a valid input has crossed the pipeline.
- R2: out_valid equals in_valid delayed by exactly 4 clock cycles. A cycle with in_valid low yields a cycle with out_valid low, 4 cycles later.
- R3: A lane whose twiddle index is 0 passes its sample into the combine unchanged and exactly, with no multiplier scaling.
- R4: For index k the twiddle is W = cos(2*pi*k/N) - j*sin(2*pi*k/N), with N = 2^LOG2N. Cosine and sine are each rounded to 15 fraction bits, and a magnitude of 1.0 saturates to 32767. All four lanes read one quarter-wave sine table.
- R5: A rotated lane is ((x_re*c + x_im*s) + j(x_im*c - x_re*s)) / 2^15, rounded to nearest with ties toward +infinity. Here c and s are the table values. Indices N/4, N/2 and 3N/4 use the exact table pairs (c,s) = (0,32767), (-32767,0) and (0,-32767).
- R6: With rotated legs a, b, c, d: X0 = a+b+c+d, X1 = a-jb-c+jd, X2 = a-b+c-d, X3 = a+jb-c-jd.
- R7: A new butterfly is accepted on every clock with in_valid high. Back-to-back butterflies are computed independently, and none is dropped or repeated.
- R8: Rotated legs are DW+1 bits and outputs are DW+3 bits signed. All-full-scale inputs such as -32768 on every lane and part, at index 0, give X0 = -131072 without wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input butterfly strobe |
| in_re | input | 4*DW | Real parts of legs a..d, lane l at [l*DW +: DW] |
| in_im | input | 4*DW | Imaginary parts of legs a..d |
| tw_idx | input | 4*LOG2N | Twiddle index per lane, lane l at [l*LOG2N +: LOG2N] |
| out_valid | output | 1 | Result strobe, in_valid delayed by 4 |
| out_re | output | 4*(DW+3) | Real parts of X0..X3 |
| out_im | output | 4*(DW+3) | Imaginary parts of X0..X3 |

## Verification
A corrupted entry in the sine table appears 4 cycles later, only on lanes that addressed that index, as an error of a few LSBs or more in all four outputs. A slip in the strobe pipeline shows at once as out_valid landing on the wrong cycle against an input pattern with gaps. A rounding fault is invisible for generic indices but gives a one-LSB error in the exact quarter-turn cases, so those are compared bit-exact. A fault in the bypass or the combine breaks the exact index-0 patterns in the very first output cycle.

// File: rtl/r4b_pkg.sv
package r4b_pkg;

  localparam int LANES    = 4;
  localparam int PIPE_LAT = 4;

  typedef enum logic [1:0] {
    QD_0 = 2'd0,
    QD_1 = 2'd1,
    QD_2 = 2'd2,
    QD_3 = 2'd3
  } quad_e;

  // sin(pi/2 * k/qn) rounded to 'frac' fraction bits, saturated below 1.0.
  // Taylor series in Q30 integer arithmetic, evaluated at elaboration.
  function automatic int quarter_sin(input int k, input int qn, input int frac);
    longint x;
    longint term;
    longint acc;
    longint res;
    longint lim;
    x    = (64'sd1686629713 * longint'(k)) / longint'(qn);
    term = x;
    acc  = x;
    for (int n = 1; n <= 8; n++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -(term / longint'((2 * n) * (2 * n + 1)));
      acc  = acc + term;
    end
    res = (acc + (64'sd1 <<< (29 - frac))) >>> (30 - frac);
    lim = (64'sd1 <<< frac) - 64'sd1;
    if (res > lim) res = lim;
    if (res < 0) res = 0;
    return int'(res);
  endfunction

  // Round-half-up right shift of a signed product sum.
  function automatic longint round_q(input longint p, input int frac);
    return (p + (64'sd1 <<< (frac - 1))) >>> frac;
  endfunction

endpackage

// File: rtl/r4b_twiddle_rom.sv
module r4b_twiddle_rom
  import r4b_pkg::*;
#(
  parameter int LOG2N = 12,
  parameter int TW    = 16
) (
  input  logic [LANES-1:0][LOG2N-1:0] idx,
  output logic [LANES-1:0][TW-1:0]    cos_o,
  output logic [LANES-1:0][TW-1:0]    sin_o
);
  localparam int QB = LOG2N - 2;
  localparam int QN = 1 << QB;

  // One quarter-wave table shared by every lane (QN+1 entries).
  logic [TW-1:0] qsin [QN+1];

  for (genvar k = 0; k <= QN; k++) begin : g_tab
    assign qsin[k] = TW'(quarter_sin(k, QN, TW - 1));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_port
    quad_e         quad;
    logic [QB:0]   r_fwd;
    logic [QB:0]   r_rev;
    logic [TW-1:0] s_fwd;
    logic [TW-1:0] s_rev;

    assign quad  = quad_e'(idx[l][LOG2N-1 -: 2]);
    assign r_fwd = {1'b0, idx[l][QB-1:0]};
    assign r_rev = (QB+1)'(QN) - r_fwd;
    assign s_fwd = qsin[r_fwd];
    assign s_rev = qsin[r_rev];

    always_comb begin
      unique case (quad)
        QD_0: begin cos_o[l] = s_rev;       sin_o[l] = s_fwd;       end
        QD_1: begin cos_o[l] = -s_fwd;      sin_o[l] = s_rev;       end
        QD_2: begin cos_o[l] = -s_rev;      sin_o[l] = -s_fwd;      end
        default: begin cos_o[l] = s_fwd;    sin_o[l] = -s_rev;      end
      endcase
    end
  end

endmodule

// File: rtl/r4b_rotator.sv
module r4b_rotator
  import r4b_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] x_re,
  input  logic [DW-1:0] x_im,
  input  logic [TW-1:0] c_in,
  input  logic [TW-1:0] s_in,
  input  logic          byp,
  output logic [DW:0]   w_re,
  output logic [DW:0]   w_im
);
  localparam int PW = DW + TW;

  logic signed [PW-1:0] p_rc, p_is, p_ic, p_rs;
  logic                 byp_q;
  logic [DW-1:0]        xr_q, xi_q;
  longint               sum_re, sum_im;
  logic [DW:0]          w_re_nxt, w_im_nxt;

  // Multiply stage: four partial products per lane.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rc  <= '0;
      p_is  <= '0;
      p_ic  <= '0;
      p_rs  <= '0;
      byp_q <= 1'b0;
      xr_q  <= '0;
      xi_q  <= '0;
    end else begin
      p_rc  <= PW'($signed(x_re)) * PW'($signed(c_in));
      p_is  <= PW'($signed(x_im)) * PW'($signed(s_in));
      p_ic  <= PW'($signed(x_im)) * PW'($signed(c_in));
      p_rs  <= PW'($signed(x_re)) * PW'($signed(s_in));
      byp_q <= byp;
      xr_q  <= x_re;
      xi_q  <= x_im;
    end
  end

  always_comb begin
    sum_re = longint'(p_rc) + longint'(p_is);
    sum_im = longint'(p_ic) - longint'(p_rs);
    if (byp_q) begin
      w_re_nxt = {xr_q[DW-1], xr_q};
      w_im_nxt = {xi_q[DW-1], xi_q};
    end else begin
      w_re_nxt = (DW+1)'(round_q(sum_re, TW - 1));
      w_im_nxt = (DW+1)'(round_q(sum_im, TW - 1));
    end
  end

  // Rounding stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_re <= '0;
      w_im <= '0;
    end else begin
      w_re <= w_re_nxt;
      w_im <= w_im_nxt;
    end
  end

endmodule

// File: rtl/r4b_combine.sv
module r4b_combine
  import r4b_pkg::*;
#(
  parameter int WW = 17,
  parameter int OW = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0][WW-1:0] w_re,
  input  logic [LANES-1:0][WW-1:0] w_im,
  output logic [LANES-1:0][OW-1:0] y_re,
  output logic [LANES-1:0][OW-1:0] y_im
);
  logic signed [OW-1:0] ar, ai, br, bi, cr, ci, dr, di;
  logic [LANES-1:0][OW-1:0] yr_nxt, yi_nxt;

  always_comb begin
    ar = OW'($signed(w_re[0]));  ai = OW'($signed(w_im[0]));
    br = OW'($signed(w_re[1]));  bi = OW'($signed(w_im[1]));
    cr = OW'($signed(w_re[2]));  ci = OW'($signed(w_im[2]));
    dr = OW'($signed(w_re[3]));  di = OW'($signed(w_im[3]));
    // -j*v = (v_im, -v_re); +j*v = (-v_im, v_re)
    yr_nxt[0] = ar + br + cr + dr;
    yi_nxt[0] = ai + bi + ci + di;
    yr_nxt[1] = ar + bi - cr - di;
    yi_nxt[1] = ai - br - ci + dr;
    yr_nxt[2] = ar - br + cr - dr;
    yi_nxt[2] = ai - bi + ci - di;
    yr_nxt[3] = ar - bi - cr + di;
    yi_nxt[3] = ai + br - ci - dr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_re <= '0;
      y_im <= '0;
    end else begin
      y_re <= yr_nxt;
      y_im <= yi_nxt;
    end
  end

endmodule

// File: rtl/r4_bfly_stage.sv
module r4_bfly_stage
  import r4b_pkg::*;
#(
  parameter int DW    = 16,
  parameter int TW    = 16,
  parameter int LOG2N = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [LANES-1:0][DW-1:0]      in_re,
  input  logic [LANES-1:0][DW-1:0]      in_im,
  input  logic [LANES-1:0][LOG2N-1:0]   tw_idx,
  output logic                          out_valid,
  output logic [LANES-1:0][DW+2:0]      out_re,
  output logic [LANES-1:0][DW+2:0]      out_im
);
  localparam int WW = DW + 1;
  localparam int OW = DW + 3;

  // Named internal events, observed by the bound checker.
  logic [LANES-1:0][DW-1:0]    s1_re, s1_im;
  logic [LANES-1:0][LOG2N-1:0] s1_idx;
  logic [LANES-1:0][TW-1:0]    rom_cos, rom_sin;
  logic [LANES-1:0]            lane_byp;
  logic [LANES-1:0][WW-1:0]    w_re, w_im;
  logic [PIPE_LAT-1:0]         vpipe;

  // Capture stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_re  <= '0;
      s1_im  <= '0;
      s1_idx <= '0;
      vpipe  <= '0;
    end else begin
      s1_re  <= in_re;
      s1_im  <= in_im;
      s1_idx <= tw_idx;
      vpipe  <= {vpipe[PIPE_LAT-2:0], in_valid};
    end
  end

  assign out_valid = vpipe[PIPE_LAT-1];

  r4b_twiddle_rom #(.LOG2N(LOG2N), .TW(TW)) u_rom (
    .idx   (s1_idx),
    .cos_o (rom_cos),
    .sin_o (rom_sin)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_byp[l] = (s1_idx[l] == '0);

    r4b_rotator #(.DW(DW), .TW(TW)) u_rot (
      .clk   (clk),
      .rst_n (rst_n),
      .x_re  (s1_re[l]),
      .x_im  (s1_im[l]),
      .c_in  (rom_cos[l]),
      .s_in  (rom_sin[l]),
      .byp   (lane_byp[l]),
      .w_re  (w_re[l]),
      .w_im  (w_im[l])
    );
  end

  r4b_combine #(.WW(WW), .OW(OW)) u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .w_re  (w_re),
    .w_im  (w_im),
    .y_re  (out_re),
    .y_im  (out_im)
  );

endmodule

// File: rtl/r4b_checker.sv
module r4b_checker
  import r4b_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       out_valid,
  input logic [LANES-1:0]           lane_byp,
  input logic [LANES-1:0][DW-1:0]   s1_re,
  input logic [LANES-1:0][DW-1:0]   s1_im,
  input logic [LANES-1:0][DW:0]     w_re,
  input logic [LANES-1:0][DW:0]     w_im,
  input logic [LANES-1:0][TW-1:0]   rom_cos,
  input logic [LANES-1:0][TW-1:0]   rom_sin,
  input logic [LANES-1:0][DW+2:0]   out_re,
  input logic [LANES-1:0][DW+2:0]   out_im
);
  localparam longint UNIT2 = 64'sd1 <<< (2 * (TW - 1));
  localparam longint SLACK = 64'sd1 <<< (TW + 1);

  logic [2:0] cyc;
  int         osum_re, osum_im, a_re, a_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc < 3'd4) cyc <= cyc + 3'd1;
  end

  always_comb begin
    osum_re = 0;
    osum_im = 0;
    for (int l = 0; l < LANES; l++) begin
      osum_re = osum_re + int'($signed(out_re[l]));
      osum_im = osum_im + int'($signed(out_im[l]));
    end
    a_re = int'($signed(w_re[0]));
    a_im = int'($signed(w_im[0]));
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!out_valid);
    end
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R6
  combine_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1) |-> ((osum_re == 4 * $past(a_re)) && (osum_im == 4 * $past(a_im))));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    longint nrm;
    assign nrm = longint'($signed(rom_cos[l])) * longint'($signed(rom_cos[l]))
               + longint'($signed(rom_sin[l])) * longint'($signed(rom_sin[l]));

    // R4
    tw_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nrm >= UNIT2 - SLACK) && (nrm <= UNIT2 + SLACK));

    // R3
    byp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc >= 3'd2) && $past(lane_byp[l], 2)) |->
        ((w_re[l] == {$past(s1_re[l][DW-1], 2), $past(s1_re[l], 2)}) &&
         (w_im[l] == {$past(s1_im[l][DW-1], 2), $past(s1_im[l], 2)})));
  end

endmodule

bind r4_bfly_stage r4b_checker #(.DW(DW), .TW(TW)) u_chk (.*);

// File: tb/sim_r4_bfly_stage.sv
module sim_r4_bfly_stage;
  localparam int  CLK_PERIOD = 10;
  localparam int  DW = 16;
  localparam int  TW = 16;
  localparam int  LOG2N = 12;
  localparam int  NPTS = 1 << LOG2N;
  localparam int  OW = DW + 3;
  localparam real PI = 3.14159265358979323846;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic [3:0][DW-1:0]      in_re = '0;
  logic [3:0][DW-1:0]      in_im = '0;
  logic [3:0][LOG2N-1:0]   tw_idx = '0;
  logic                    out_valid;
  logic [3:0][OW-1:0]      out_re, out_im;

  int checks = 0;
  int errors = 0;
  int tol = 0;
  int unsigned seed = 32'h1234_5678;

  int vre [64][4];
  int vim [64][4];
  int vix [64][4];
  bit vval [64];
  int ere [64][4];
  int eim [64][4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  r4_bfly_stage #(.DW(DW), .TW(TW), .LOG2N(LOG2N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .tw_idx(tw_idx),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  function automatic int rnd_s16();
    int unsigned r;
    r = rnd();
    return int'($signed(r[23:8]));
  endfunction

  function automatic int qround(input real v);
    real m;
    int  q;
    m = (v < 0.0) ? -v : v;
    q = $rtoi(m * 32768.0 + 0.5);
    if (q > 32767) q = 32767;
    return (v < 0.0) ? -q : q;
  endfunction

  function automatic int rnd_half(input longint p);
    return int'($floor(real'(p) / 32768.0 + 0.5));
  endfunction

  // Builds the expected outputs of vector i from the requirements.
  function automatic void model(input int i);
    int wr [4];
    int wi [4];
    int c, s;
    real th;
    for (int l = 0; l < 4; l++) begin
      if (vix[i][l] == 0) begin
        wr[l] = vre[i][l];
        wi[l] = vim[i][l];
      end else begin
        th = 2.0 * PI * real'(vix[i][l]) / real'(NPTS);
        c  = qround($cos(th));
        s  = qround($sin(th));
        wr[l] = rnd_half(longint'(vre[i][l]) * c + longint'(vim[i][l]) * s);
        wi[l] = rnd_half(longint'(vim[i][l]) * c - longint'(vre[i][l]) * s);
      end
    end
    ere[i][0] = wr[0] + wr[1] + wr[2] + wr[3];
    eim[i][0] = wi[0] + wi[1] + wi[2] + wi[3];
    ere[i][1] = wr[0] + wi[1] - wr[2] - wi[3];
    eim[i][1] = wi[0] - wr[1] - wi[2] + wr[3];
    ere[i][2] = wr[0] - wr[1] + wr[2] - wr[3];
    eim[i][2] = wi[0] - wi[1] + wi[2] - wi[3];
    ere[i][3] = wr[0] - wi[1] - wr[2] + wi[3];
    eim[i][3] = wi[0] + wr[1] - wi[2] - wr[3];
  endfunction

  function automatic void set_lane(input int i, input int l, input int re, input int im, input int ix);
    vre[i][l] = re;
    vim[i][l] = im;
    vix[i][l] = ix;
  endfunction

  task automatic chk_int(input string req, input string what, input int got, input int exp, input int tl);
    int d;
    checks++;
    d = got - exp;
    if (d < 0) d = -d;
    if (d > tl) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Streams vectors 0..n-1, then checks each result 4 cycles after entry.
  task automatic run_seq(input int n, input string req);
    for (int i = 0; i < n; i++) model(i);
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        chk_int("R2", $sformatf("out_valid slot %0d", i - 4), int'(out_valid), int'(vval[i - 4]), 0);
        if (vval[i - 4]) begin
          for (int l = 0; l < 4; l++) begin
            chk_int(req, $sformatf("vec %0d X%0d re", i - 4, l), int'($signed(out_re[l])), ere[i - 4][l], tol);
            chk_int(req, $sformatf("vec %0d X%0d im", i - 4, l), int'($signed(out_im[l])), eim[i - 4][l], tol);
          end
        end
      end
      if (i < n) begin
        in_valid = vval[i];
        for (int l = 0; l < 4; l++) begin
          in_re[l]  = DW'(vre[i][l]);
          in_im[l]  = DW'(vim[i][l]);
          tw_idx[l] = LOG2N'(vix[i][l]);
        end
      end else begin
        in_valid = 1'b0;
        in_re    = '0;
        in_im    = '0;
        tw_idx   = '0;
      end
    end
  endtask

  // R1: quiet outputs during and right after reset.
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_int("R1", "out_valid in reset", int'(out_valid), 0, 0);
    chk_int("R1", "out_re X0 in reset", int'($signed(out_re[0])), 0, 0);
    chk_int("R1", "out_im X3 in reset", int'($signed(out_im[3])), 0, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk_int("R1", $sformatf("out_valid idle %0d", k), int'(out_valid), 0, 0);
    end
  endtask

  // R3, R6, R8: index-0 bypass with exact patterns.
  task automatic t_bypass();
    tol = 0;
    for (int i = 0; i < 5; i++) begin
      vval[i] = 1'b1;
      for (int l = 0; l < 4; l++) set_lane(i, l, 0, 0, 0);
    end
    set_lane(0, 0, 1000, -2000, 0);
    for (int l = 0; l < 4; l++) set_lane(1, l, 100, 50, 0);
    set_lane(2, 1, 0, 300, 0);
    // R8 full scale negative on every lane and part
    for (int l = 0; l < 4; l++) set_lane(3, l, -32768, -32768, 0);
    set_lane(4, 0, 32767, -32768, 0);
    set_lane(4, 1, -32768, 32767, 0);
    set_lane(4, 2, 32767, 32767, 0);
    set_lane(4, 3, -32768, -32768, 0);
    run_seq(5, "R3/R6/R8");
  endtask

  // R5: quarter-turn indices use exact table pairs, so rounding is bit-exact.
  task automatic t_exact_rot();
    tol = 0;
    for (int i = 0; i < 3; i++) vval[i] = 1'b1;
    set_lane(0, 0, 1000, 3, 2048);
    set_lane(0, 1, 1000, -7, 1024);
    set_lane(0, 2, 1000, 5, 3072);
    set_lane(0, 3, 0, 0, 0);
    set_lane(1, 0, -12345, 777, 1024);
    set_lane(1, 1, 3, -3, 3072);
    set_lane(1, 2, 32767, -32768, 2048);
    set_lane(1, 3, 11, 22, 0);
    set_lane(2, 0, 1, 1, 3072);
    set_lane(2, 1, -1, 2, 2048);
    set_lane(2, 2, 20000, -20000, 1024);
    set_lane(2, 3, -5, 9, 3072);
    run_seq(3, "R5");
  endtask

  // R4: general twiddle indices across the circle.
  task automatic t_twiddle();
    int idxs [8] = '{1, 511, 777, 1500, 2049, 2900, 3500, 4095};
    tol = 2;
    for (int i = 0; i < 8; i++) begin
      vval[i] = 1'b1;
      for (int l = 0; l < 4; l++)
        set_lane(i, l, rnd_s16(), rnd_s16(), idxs[(i + l) % 8]);
    end
    run_seq(8, "R4");
  endtask

  // R7: back-to-back butterflies with mixed indices.
  task automatic t_stream();
    tol = 2;
    for (int i = 0; i < 20; i++) begin
      vval[i] = 1'b1;
      for (int l = 0; l < 4; l++) begin
        int unsigned r;
        r = rnd();
        set_lane(i, l, rnd_s16(), rnd_s16(), (r[3:0] == 4'd0) ? 0 : int'(r[27:16]));
      end
    end
    run_seq(20, "R7");
  endtask

  // R2: strobe pattern with gaps.
  task automatic t_gaps();
    bit pat [12] = '{1, 0, 1, 1, 0, 0, 1, 0, 0, 0, 1, 1};
    tol = 2;
    for (int i = 0; i < 12; i++) begin
      vval[i] = pat[i];
      for (int l = 0; l < 4; l++) set_lane(i, l, rnd_s16(), rnd_s16(), int'(rnd() % NPTS));
    end
    run_seq(12, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_exact_rot();
    t_twiddle();
    t_stream();
    t_gaps();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule